// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives a pulse-width modulated pin from an 8-bit period setting and a 10-bit duty setting. A time base made of an 8-bit coarse count and a 2-bit fine count advances one step per clock. A period lasts from a time base of zero until the coarse count reaches the period setting and the fine count reaches its top value. The output goes high when a period starts and goes low when the 10-bit time base equals the active duty.

Software writes the duty at any time, as an 8-bit upper field and a 2-bit lower field, each with its own write strobe. These writes fill a buffer. The active duty is copied from the buffer only when a new period begins, so a change never cuts a period short or stretches it. A zero duty keeps the pin low for the whole period. A duty at or above the period span keeps it high for the whole period. The period setting itself takes effect at once. While the block is disabled, the pin and its output enable are low and the time base is held at zero.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After reset, pwm_o and pwm_oe are 0, the period setting is 255 and the buffered duty is 0. Enabling without any write therefore gives a constant low output.
- R2: With period setting P, a period lasts exactly (P+1)*4 clock cycles. The time base is {coarse, fine}, with the coarse count in the upper 8 bits and the fine count in the lower 2 bits.
- R3: With a nonzero active duty D that is below the span (P+1)*4, pwm_o is high for the first D cycles of each period and low for the rest.
- R4: A duty write during a period leaves the current period unchanged. The written value first shapes the period that starts after the write.
- R5: With an active duty of 0, pwm_o stays low for the whole period and is not set at its start.
- R6: With an active duty at or above (P+1)*4, pwm_o stays high for the whole period.
- R7: The duty is {duty_hi, duty_lo}, with duty_hi as bits 9..2 and duty_lo as bits 1..0. Each strobe updates only its own field.
- R8: A period write takes effect on the next clock. If the new setting is below the current coarse count, the period ends at the next cycle whose fine count is 3.
- R9: While en is 0, pwm_o and pwm_oe are 0 and the time base is held at zero. The first clock edge with en high starts a period with the buffered duty and raises pwm_oe.
- R10: If a duty write and a period start fall on the same clock edge, the new period uses the duty held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time base step per cycle |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | PWM mode enable |
| per_we | input | 1 | Period setting write strobe |
| per_wdata | input | 8 | New period setting |
| duty_hi_we | input | 1 | Upper duty field write strobe |
| duty_hi_wdata | input | 8 | Upper 8 bits of the duty |
| duty_lo_we | input | 1 | Lower duty field write strobe |
| duty_lo_wdata | input | 2 | Lower 2 bits of the duty |
| pwm_o | output | 1 | PWM output, registered |
| pwm_oe | output | 1 | Output enable, high while running |

## Verification
A wrong time base shows as a wrong spacing between rising edges of pwm_o, and the error is visible within one period. A wrong active duty or a buffer that loads too early shows as a wrong high count in the period where the write lands or in the one after it. The bench compares pwm_o and pwm_oe on every cycle against a model built from the requirements, so a single bad cycle is reported in the cycle where it occurs. Directed cases cover zero duty, full and over-span duty, a write on the boundary edge, a period shrink below the count, and disable followed by re-enable.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  // Default geometry of the time base
  localparam int PWM_PER_W_DEF  = 8;
  localparam int PWM_FINE_W_DEF = 2;

  // What the time base does on the coming clock edge
  typedef enum logic [1:0] {
    TB_IDLE  = 2'd0,  // disabled: held at zero
    TB_START = 2'd1,  // first enabled edge: begin a period
    TB_WRAP  = 2'd2,  // end of period: begin the next one
    TB_COUNT = 2'd3   // ordinary step
  } tb_evt_e;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int PER_W  = PWM_PER_W_DEF,
  parameter int FINE_W = PWM_FINE_W_DEF,
  localparam int DUTY_W = PER_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              per_we,
  input  logic [PER_W-1:0]  per_wdata,
  input  logic              hi_we,
  input  logic [PER_W-1:0]  hi_wdata,
  input  logic              lo_we,
  input  logic [FINE_W-1:0] lo_wdata,
  output logic [PER_W-1:0]  per_q,
  output logic [DUTY_W-1:0] duty_buf
);

  logic [PER_W-1:0]  hi_q;
  logic [FINE_W-1:0] lo_q;

  // Period setting: live immediately, resets to the longest period
  always_ff @(posedge clk) begin
    if (rst)         per_q <= '1;
    else if (per_we) per_q <= per_wdata;
  end

  // Duty buffer fields, each with its own strobe
  always_ff @(posedge clk) begin
    if (rst)        hi_q <= '0;
    else if (hi_we) hi_q <= hi_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        lo_q <= '0;
    else if (lo_we) lo_q <= lo_wdata;
  end

  assign duty_buf = {hi_q, lo_q};

  // R7: a strobe on one field leaves the other field unchanged
  lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !lo_we) |=> (duty_buf[FINE_W-1:0] == $past(duty_buf[FINE_W-1:0])));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_dbuf_pkg::*;
#(
  parameter int PER_W  = PWM_PER_W_DEF,
  parameter int FINE_W = PWM_FINE_W_DEF,
  localparam int DUTY_W = PER_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PER_W-1:0]  per_q,
  output logic [DUTY_W-1:0] tb_q,
  output logic              run_q,
  output tb_evt_e           evt
);

  logic [PER_W-1:0]  coarse;
  logic [FINE_W-1:0] fine;
  logic              at_end;

  assign coarse = tb_q[DUTY_W-1:FINE_W];
  assign fine   = tb_q[FINE_W-1:0];

  // The period ends on the top fine step once the coarse count has
  // reached the setting, or passed it after the setting was lowered
  assign at_end = (fine == {FINE_W{1'b1}}) && (coarse >= per_q);

  always_comb begin
    if (!en)         evt = TB_IDLE;
    else if (!run_q) evt = TB_START;
    else if (at_end) evt = TB_WRAP;
    else             evt = TB_COUNT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q  <= '0;
      run_q <= 1'b0;
    end else begin
      case (evt)
        TB_IDLE:  begin tb_q <= '0; run_q <= 1'b0; end
        TB_START: begin tb_q <= '0; run_q <= 1'b1; end
        TB_WRAP:  tb_q <= '0;
        default:  tb_q <= tb_q + 1'b1;
      endcase
    end
  end

  // R9: disable holds the time base at zero and stops the run
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (tb_q == '0 && !run_q));

  // R2: an ordinary step advances the time base by exactly one
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (evt == TB_COUNT) |=> (tb_q == DUTY_W'($past(tb_q) + 1'b1)));

  // R8: top fine step at or beyond the period setting restarts the count
  wrap_end_chk: assert property (@(posedge clk) disable iff (rst)
    (en && run_q && fine == {FINE_W{1'b1}} && coarse >= per_q) |=> (tb_q == '0));

endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch
  import pwm_dbuf_pkg::*;
#(
  parameter int DUTY_W = PWM_PER_W_DEF + PWM_FINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  tb_evt_e           evt,
  input  logic [DUTY_W-1:0] duty_buf,
  output logic [DUTY_W-1:0] act_q
);

  logic load;

  assign load = (evt == TB_START) || (evt == TB_WRAP);

  // Active duty: only copied from the buffer when a period begins
  always_ff @(posedge clk) begin
    if (rst)       act_q <= '0;
    else if (load) act_q <= duty_buf;
  end

  // R4: no change to the active duty inside a period
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (evt == TB_COUNT) |=> $stable(act_q));

  // R10: a period start takes the buffer value seen before the edge
  act_load_chk: assert property (@(posedge clk) disable iff (rst)
    (evt == TB_WRAP) |=> (act_q == $past(duty_buf)));

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
  import pwm_dbuf_pkg::*;
#(
  parameter int DUTY_W = PWM_PER_W_DEF + PWM_FINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  tb_evt_e           evt,
  input  logic [DUTY_W-1:0] tb_q,
  input  logic [DUTY_W-1:0] duty_buf,
  input  logic [DUTY_W-1:0] act_q,
  output logic              pwm_o,
  output logic              oe_o
);

  logic [DUTY_W-1:0] tb_nxt;
  logic              hit;

  assign tb_nxt = tb_q + 1'b1;
  assign hit    = (tb_nxt == act_q);

  // Set at a period start unless the new duty is zero, clear on match
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      case (evt)
        TB_IDLE: begin
          pwm_o <= 1'b0;
          oe_o  <= 1'b0;
        end
        TB_START, TB_WRAP: begin
          pwm_o <= |duty_buf;
          oe_o  <= 1'b1;
        end
        default: begin
          if (hit) pwm_o <= 1'b0;
        end
      endcase
    end
  end

  // R5: a zero duty never sets the pin at the period start
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt == TB_START || evt == TB_WRAP) && duty_buf == '0) |=> !pwm_o);

  // R9: disable forces pin and enable low
  off_state_chk: assert property (@(posedge clk) disable iff (rst)
    (evt == TB_IDLE) |=> (!pwm_o && !oe_o));

  // R3: while running the pin is high exactly when time base < active duty
  high_window_chk: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> (pwm_o == (tb_q < act_q)));

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
  import pwm_dbuf_pkg::*;
#(
  parameter int PER_W  = PWM_PER_W_DEF,
  parameter int FINE_W = PWM_FINE_W_DEF,
  localparam int DUTY_W = PER_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              per_we,
  input  logic [PER_W-1:0]  per_wdata,
  input  logic              duty_hi_we,
  input  logic [PER_W-1:0]  duty_hi_wdata,
  input  logic              duty_lo_we,
  input  logic [FINE_W-1:0] duty_lo_wdata,
  output logic              pwm_o,
  output logic              pwm_oe
);

  logic [PER_W-1:0]  per_q;
  logic [DUTY_W-1:0] duty_buf;
  logic [DUTY_W-1:0] tb_q;
  logic [DUTY_W-1:0] act_q;
  logic              run_q;
  tb_evt_e           evt;

  pwm_cfg_regs #(.PER_W(PER_W), .FINE_W(FINE_W)) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .per_we   (per_we),
    .per_wdata(per_wdata),
    .hi_we    (duty_hi_we),
    .hi_wdata (duty_hi_wdata),
    .lo_we    (duty_lo_we),
    .lo_wdata (duty_lo_wdata),
    .per_q    (per_q),
    .duty_buf (duty_buf)
  );

  pwm_timebase #(.PER_W(PER_W), .FINE_W(FINE_W)) tb_i (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .per_q(per_q),
    .tb_q (tb_q),
    .run_q(run_q),
    .evt  (evt)
  );

  pwm_duty_latch #(.DUTY_W(DUTY_W)) latch_i (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .duty_buf(duty_buf),
    .act_q   (act_q)
  );

  pwm_outstage #(.DUTY_W(DUTY_W)) out_i (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .tb_q    (tb_q),
    .duty_buf(duty_buf),
    .act_q   (act_q),
    .pwm_o   (pwm_o),
    .oe_o    (pwm_oe)
  );

  // R9: output enable follows the run state of the time base
  oe_run_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_oe == run_q);

endmodule

// File: tb/pwm_dbuf_gen_tb.sv
module pwm_dbuf_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       per_we = 1'b0;
  logic [7:0] per_wdata = '0;
  logic       duty_hi_we = 1'b0;
  logic [7:0] duty_hi_wdata = '0;
  logic       duty_lo_we = 1'b0;
  logic [1:0] duty_lo_wdata = '0;
  logic       pwm_o;
  logic       pwm_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dbuf_gen dut_i (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .per_we       (per_we),
    .per_wdata    (per_wdata),
    .duty_hi_we   (duty_hi_we),
    .duty_hi_wdata(duty_hi_wdata),
    .duty_lo_we   (duty_lo_we),
    .duty_lo_wdata(duty_lo_wdata),
    .pwm_o        (pwm_o),
    .pwm_oe       (pwm_oe)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  bit       m_run = 1'b0;
  int       m_tb = 0;
  int       m_act = 0;
  int       m_per = 255;
  int       m_hi = 0;
  int       m_lo = 0;

  function automatic int span_of(input int p);
    return (p + 1) * 4;
  endfunction

  function automatic bit exp_pwm();
    return m_run && (m_tb < m_act);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 1'b0; m_tb = 0; m_act = 0; m_per = 255; m_hi = 0; m_lo = 0;
    end else begin
      if (!en) begin
        m_run = 1'b0; m_tb = 0;
      end else if (!m_run || ((m_tb % 4) == 3 && (m_tb / 4) >= m_per)) begin
        m_run = 1'b1; m_tb = 0; m_act = m_hi * 4 + m_lo;
      end else begin
        m_tb = m_tb + 1;
      end
      if (per_we)     m_per = per_wdata;
      if (duty_hi_we) m_hi  = duty_hi_wdata;
      if (duty_lo_we) m_lo  = duty_lo_wdata;
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(tag, pwm_o, exp_pwm(), "pwm_o per cycle");
      chk(tag, pwm_oe, m_run, "pwm_oe per cycle");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_per(input int v);
    per_we = 1'b1; per_wdata = 8'(v);
    @(negedge clk);
    per_we = 1'b0;
  endtask

  task automatic wr_duty(input int d);
    duty_hi_we = 1'b1; duty_hi_wdata = 8'(d >> 2);
    duty_lo_we = 1'b1; duty_lo_wdata = 2'(d);
    @(negedge clk);
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!(m_run && m_tb == 0));
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      if (pwm_o === 1'b1) h++;
      @(negedge clk);
    end
  endtask

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    int h;
    int k;
    void'($urandom(32'd20240611));

    // R1: reset state
    @(negedge clk); @(negedge clk);
    chk("R1", pwm_o, 0, "pwm_o in reset");
    chk("R1", pwm_oe, 0, "pwm_oe in reset");
    rst = 1'b0;
    cyc(2);
    chk("R9", pwm_oe, 0, "pwm_oe while disabled");

    // R1: buffered duty is zero after reset, so output stays low
    tag = "R1";
    en = 1'b1;
    cyc(1);
    chk("R1", pwm_oe, 1, "pwm_oe after enable");
    count_high(60, h);
    chk("R1", h, 0, "high count with reset duty");

    // R3 / R7: period 9 (span 40), duty 13 = hi 3, lo 1
    tag = "R3";
    wr_per(9);
    wr_duty(13);
    wait_start(); wait_start();
    count_high(40, h);
    chk("R3", h, 13, "high cycles for duty 13");
    chk("R7", h, 3 * 4 + 1, "duty composed of hi/lo fields");

    // R2: spacing between rising edges equals (P+1)*4
    tag = "R2";
    while (pwm_o !== 1'b1) @(negedge clk);
    while (pwm_o !== 1'b0) @(negedge clk);
    k = 0;
    while (pwm_o !== 1'b1) begin k++; @(negedge clk); end
    chk("R2", k, span_of(9) - 13, "low stretch in period");
    k = 0;
    while (pwm_o !== 1'b0) begin k++; @(negedge clk); end
    chk("R2", k, 13, "high stretch in period");

    // R4: mid-period write does not change the running period
    tag = "R4";
    wait_start();
    count_high(5, h);
    duty_hi_we = 1'b1; duty_hi_wdata = 8'd7; duty_lo_we = 1'b1; duty_lo_wdata = 2'd2;
    @(negedge clk);
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    if (pwm_o === 1'b1) h++;
    count_high(34, k);
    chk("R4", h + k, 13, "old duty kept in current period");
    count_high(40, h);
    chk("R4", h, 30, "new duty in next period");

    // R5: zero duty gives no high cycle at all
    tag = "R5";
    wr_duty(0);
    wait_start();
    count_high(40, h);
    chk("R5", h, 0, "high cycles for zero duty");

    // R6: duty at or above span
    tag = "R6";
    wr_duty(200);
    wait_start();
    count_high(40, h);
    chk("R6", h, 40, "high cycles for duty 200");
    wr_duty(40);
    wait_start();
    count_high(40, h);
    chk("R6", h, 40, "high cycles for duty equal to span");
    wr_duty(39);
    wait_start();
    count_high(40, h);
    chk("R3", h, 39, "high cycles for duty span-1");

    // R7: separate field strobes
    tag = "R7";
    wr_duty(22);
    duty_hi_we = 1'b1; duty_hi_wdata = 8'd5;
    @(negedge clk);
    duty_hi_we = 1'b0;
    wait_start();
    count_high(40, h);
    chk("R7", h, 22, "hi strobe keeps lo field");
    duty_lo_we = 1'b1; duty_lo_wdata = 2'd3;
    @(negedge clk);
    duty_lo_we = 1'b0;
    wait_start();
    count_high(40, h);
    chk("R7", h, 23, "lo strobe keeps hi field");

    // R8: period lowered below the current count
    tag = "R8";
    wr_per(50);
    wait_start(); wait_start();
    cyc(100);
    wr_per(10);
    k = 0;
    while (pwm_o !== 1'b1) begin k++; @(negedge clk); end
    chk("R8", k, 3, "cycles to forced period end");
    count_high(span_of(10), h);
    chk("R8", h, 23, "high cycles after shrink");

    // R10: write on the edge that starts a period
    tag = "R10";
    wr_per(9);
    wait_start();
    while (m_tb != span_of(9) - 1) @(negedge clk);
    wr_duty(8);
    count_high(40, h);
    chk("R10", h, 23, "boundary write uses old duty");
    count_high(40, h);
    chk("R10", h, 8, "boundary write used next period");

    // R9: disable and re-enable
    tag = "R9";
    cyc(7);
    en = 1'b0;
    @(negedge clk);
    chk("R9", pwm_o, 0, "pwm_o after disable");
    chk("R9", pwm_oe, 0, "pwm_oe after disable");
    cyc(9);
    chk("R9", pwm_oe, 0, "pwm_oe held low");
    en = 1'b1;
    @(negedge clk);
    chk("R9", pwm_oe, 1, "pwm_oe on first enabled edge");
    count_high(40, h);
    chk("R9", h, 8, "first period after enable");

    // Random traffic against the model
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 100);
      per_we = (r < 3);
      per_wdata = 8'($urandom % 16);
      duty_hi_we = (r >= 3 && r < 9);
      duty_hi_wdata = 8'($urandom % 20);
      duty_lo_we = (r >= 6 && r < 12);
      duty_lo_wdata = 2'($urandom % 4);
      en = (($urandom % 60) != 0);
      @(negedge clk);
    end
    per_we = 1'b0; duty_hi_we = 1'b0; duty_lo_we = 1'b0; en = 1'b1;
    cyc(5);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule